// File: doc/BRIEF.md
# Masked Interrupt Aggregation Unit

This block gathers eight level-sensitive event flags from a two-channel serial peripheral (receiver, transmitter and counter/timer conditions) and turns them into one active-low interrupt request for a host CPU. A small register port lets the host program an enable mask, read the live event status, write a general output value, and choose which of the upper five general output pins carry a dedicated per-event interrupt line instead.

A pin in interrupt mode acts as an open-drain, active-low line. Its data output is held at 0, and its drive enable is high only while the matching event is present, so the line either pulls low or is released. A pin in general mode drives its bit of the general output register at all times. The pad drivers are outside the block: each pin is presented as a data value plus a drive enable.

The register port has no handshake. A write takes effect at the clock edge where `wr_en` is high. Read data is combinational from `addr`. The event inputs are plain levels with no flow control.

Top module: `intr_aggregator`

## Requirements
- R1: While `rst_n` is low, the registers clear as follows: mask = 0, general output = 0, pin mode = 0. Outputs are `irq_n` = 1, every `pin_o` = 0 and every `pin_oe` = 1. With an all-zero mask, no request asserts after reset.
- R2: Reading address 0 returns the event inputs as sampled at the most recent clock edge, one bit per event, with bit i meaning event i. Reading does not clear any bit. A bit clears only when its input drops.
- R3: After each clock edge, `irq_n` is 0 exactly when, at that edge, some event input was 1 and its bit in the mask register already held 1.
- R4: A write to address 1 loads the mask register at that edge, and address 1 reads the mask back. The new mask affects `irq_n` from the following edge on.
- R5: A write to address 0 changes no register. The mask, the general output value and the pin modes read back unchanged, and the outputs stay the same.
- R6: Address 3 holds the pin mode. Bit j (0 to 4) puts pin j+3 in interrupt mode. In interrupt mode, after each edge the pin shows `pin_o` = 0 and `pin_oe` equal to event input j+3 sampled at that edge.
- R7: Address 2 holds the general output register (8 bits, read/write). A pin not in interrupt mode shows `pin_o` = its general output bit and `pin_oe` = 1, both taken from the register value before the edge. Pins 0 to 2 are always in this mode.
- R8: Per-pin interrupt lines ignore the mask register. A masked-off event still pulls its pin low.
- R9: Address 3 reads the pin mode in bits 4:0 and zeros in bits 7:5. Writing bits 7:5 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 8 | Event level inputs, bit i = event i |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 status, 1 mask, 2 general output, 3 pin mode) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq_n | output | 1 | Combined active-low interrupt request |
| pin_o | output | 8 | General output pin data values |
| pin_oe | output | 8 | General output pin drive enables (0 = released) |

## Verification
The embedded assertions check four things on every cycle:
- A low request always follows a masked active event.
- A pin in interrupt mode never drives high.
- A pin in general mode is always driven.
- A status-address write never disturbs the mask, output or mode registers.

The bench scenarios cover what needs an exact reference over time:
- the one-edge timing of `irq_n` after a mask write;
- status bits that persist across reads and clear only when their input drops;
- masked-off events still reaching their dedicated pins;
- read-back of every register, including the zeroed upper mode bits.

// File: rtl/intr_agg_pkg.sv
package intr_agg_pkg;
  localparam int unsigned N_EVT   = 8;
  localparam int unsigned PIN_LO  = 3;
  localparam int unsigned N_DPIN  = N_EVT - PIN_LO;
  localparam int unsigned ADDR_W  = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_STATUS = 2'd0,
    REG_MASK   = 2'd1,
    REG_GPO    = 2'd2,
    REG_PMODE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/intr_regbank.sv
module intr_regbank
  import intr_agg_pkg::*;
#(
  parameter int unsigned W  = N_EVT,
  parameter int unsigned MW = N_DPIN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      src_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  output logic [W-1:0]      mask_q,
  output logic [W-1:0]      gpo_q,
  output logic [MW-1:0]     mode_q
);
  logic [W-1:0] status_q;
  reg_sel_e     sel;

  assign sel = reg_sel_e'(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
      gpo_q    <= '0;
      mode_q   <= '0;
    end else begin
      status_q <= src_i;
      if (wr_en) begin
        unique case (sel)
          REG_MASK:  mask_q <= wdata;
          REG_GPO:   gpo_q  <= wdata;
          REG_PMODE: mode_q <= wdata[MW-1:0];
          default:   ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (sel)
      REG_STATUS: rdata = status_q;
      REG_MASK:   rdata = mask_q;
      REG_GPO:    rdata = gpo_q;
      default:    rdata = W'(mode_q);
    endcase
  end

  a_r5_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == REG_STATUS) |=> ($stable(mask_q) && $stable(gpo_q) && $stable(mode_q)));

  a_r4_mask_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == REG_MASK) |=> (mask_q == $past(wdata)));
endmodule

// File: rtl/intr_combine.sv
module intr_combine #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] mask_q,
  output logic         irq_n
);
  logic any_hit;

  assign any_hit = |(src_i & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n <= 1'b1;
    else        irq_n <= ~any_hit;
  end

  a_r3_low_needs_masked_event: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> $past(|(src_i & mask_q)));
endmodule

// File: rtl/intr_pin_mux.sv
module intr_pin_mux
  import intr_agg_pkg::*;
#(
  parameter int unsigned W  = N_EVT,
  parameter int unsigned LO = PIN_LO,
  localparam int unsigned MW = W - LO
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  src_i,
  input  logic [W-1:0]  gpo_q,
  input  logic [MW-1:0] mode_q,
  output logic [W-1:0]  pin_o,
  output logic [W-1:0]  pin_oe
);
  for (genvar k = 0; k < W; k++) begin : g_pin
    if (k < LO) begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pin_o[k]  <= 1'b0;
          pin_oe[k] <= 1'b1;
        end else begin
          pin_o[k]  <= gpo_q[k];
          pin_oe[k] <= 1'b1;
        end
      end
    end else begin : g_dual
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pin_o[k]  <= 1'b0;
          pin_oe[k] <= 1'b1;
        end else if (mode_q[k-LO]) begin
          pin_o[k]  <= 1'b0;
          pin_oe[k] <= src_i[k];
        end else begin
          pin_o[k]  <= gpo_q[k];
          pin_oe[k] <= 1'b1;
        end
      end

      a_r6_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode_q[k-LO]) |-> !(pin_oe[k] && pin_o[k]));

      a_r7_gp_always_driven: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mode_q[k-LO]) |-> pin_oe[k]);
    end
  end
endmodule

// File: rtl/intr_aggregator.sv
module intr_aggregator
  import intr_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EVT-1:0]  src_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_EVT-1:0]  wdata,
  output logic [N_EVT-1:0]  rdata,
  output logic              irq_n,
  output logic [N_EVT-1:0]  pin_o,
  output logic [N_EVT-1:0]  pin_oe
);
  logic [N_EVT-1:0]  mask_q;
  logic [N_EVT-1:0]  gpo_q;
  logic [N_DPIN-1:0] mode_q;

  intr_regbank #(.W(N_EVT), .MW(N_DPIN)) u_regs (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .mask_q(mask_q), .gpo_q(gpo_q), .mode_q(mode_q)
  );

  intr_combine #(.W(N_EVT)) u_comb (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .mask_q(mask_q), .irq_n(irq_n)
  );

  intr_pin_mux #(.W(N_EVT), .LO(PIN_LO)) u_pins (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .gpo_q(gpo_q), .mode_q(mode_q),
    .pin_o(pin_o), .pin_oe(pin_oe)
  );
endmodule

// File: tb/intr_aggregator_bench.sv
`timescale 1ns/1ps
module intr_aggregator_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src_i = '0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_n;
  logic [7:0] pin_o, pin_oe;

  intr_aggregator u_intr_aggregator (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_n(irq_n), .pin_o(pin_o), .pin_oe(pin_oe)
  );

  always #2 clk = ~clk;

  int vectors = 0;
  int misses  = 0;
  string tag = "R1";

  // behavioural reference
  logic [7:0] m_stat, m_mask, m_gpo, m_po, m_poe;
  logic [4:0] m_mode;
  logic       m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = 0; m_mask = 0; m_gpo = 0; m_mode = 0; m_irq = 1;
      m_po = 0; m_poe = 8'hFF;
    end else begin
      m_stat = src_i;
      m_irq  = ((src_i & m_mask) == 0);
      for (int p = 0; p < 8; p++) begin
        if (p >= 3 && m_mode[p-3]) begin m_po[p] = 0; m_poe[p] = src_i[p]; end
        else begin m_po[p] = m_gpo[p]; m_poe[p] = 1; end
      end
      if (wr_en) begin
        if (addr == 1) m_mask = wdata;
        else if (addr == 2) m_gpo = wdata;
        else if (addr == 3) m_mode = wdata[4:0];
      end
    end
  end

  function automatic logic [7:0] exp_rd();
    case (addr)
      2'd0: return m_stat;
      2'd1: return m_mask;
      2'd2: return m_gpo;
      default: return {3'b000, m_mode};
    endcase
  endfunction

  task automatic compare();
    vectors++;
    if (irq_n !== m_irq) begin
      misses++;
      $display("FAIL %s irq_n act=%b exp=%b", tag, irq_n, m_irq);
    end
    if (pin_o !== m_po || pin_oe !== m_poe) begin
      misses++;
      $display("FAIL %s pins act=%h/%h exp=%h/%h", tag, pin_o, pin_oe, m_po, m_poe);
    end
    if (rdata !== exp_rd()) begin
      misses++;
      $display("FAIL %s rdata@%0d act=%h exp=%h", tag, addr, rdata, exp_rd());
    end
  endtask

  task automatic cyc(input logic [7:0] s, input logic we, input logic [1:0] a,
                     input logic [7:0] d);
    @(negedge clk);
    compare();
    src_i = s; wr_en = we; addr = a; wdata = d;
  endtask

  logic [7:0] lfsr = 8'hA5;

  initial begin
    #100000;
    misses++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    // R1: reset values, events active during reset must not raise irq
    tag = "R1";
    src_i = 8'hFF;
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1'b1;
    cyc(8'hFF, 0, 0, 0);
    cyc(8'hFF, 0, 1, 0);
    cyc(8'h00, 0, 3, 0);
    // R2: status follows inputs, reads do not clear
    tag = "R2";
    cyc(8'h5A, 0, 0, 0);
    cyc(8'h5A, 0, 0, 0);
    cyc(8'h5A, 0, 0, 0);
    cyc(8'h18, 0, 0, 0);
    cyc(8'h00, 0, 0, 0);
    // R4 / R3: mask write then irq timing
    tag = "R4";
    cyc(8'h04, 1, 1, 8'h04);
    cyc(8'h04, 0, 1, 0);
    tag = "R3";
    cyc(8'h04, 0, 0, 0);
    cyc(8'h02, 0, 0, 0);
    cyc(8'h06, 0, 0, 0);
    cyc(8'h00, 0, 0, 0);
    // R5: writes to status address ignored
    tag = "R5";
    cyc(8'h81, 1, 0, 8'hFF);
    cyc(8'h81, 0, 1, 0);
    cyc(8'h81, 0, 2, 0);
    cyc(8'h81, 0, 3, 0);
    // R7: general output drive
    tag = "R7";
    cyc(8'h00, 1, 2, 8'hC3);
    cyc(8'h00, 0, 2, 0);
    cyc(8'h00, 1, 2, 8'h3C);
    cyc(8'h00, 0, 2, 0);
    // R9: mode register upper bits
    tag = "R9";
    cyc(8'h00, 1, 3, 8'hEA);
    cyc(8'h00, 0, 3, 0);
    // R6 / R8: per-pin lines, masked-off events still reach pins
    tag = "R6";
    cyc(8'h00, 1, 3, 8'h1F);
    cyc(8'hF8, 0, 3, 0);
    cyc(8'hA8, 0, 0, 0);
    tag = "R8";
    cyc(8'hF0, 1, 1, 8'h00);
    cyc(8'hF0, 0, 1, 0);
    cyc(8'h50, 0, 0, 0);
    // mixed pseudo-random traffic across all requirements
    tag = "R3 R6 R7";
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      cyc(lfsr, lfsr[0] & lfsr[6], lfsr[2:1], {lfsr[3:0], lfsr[7:4]});
    end
    cyc(8'h00, 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule